// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 128K bytes (17 address bits, 8 data bits). It takes one request at a time over a valid/ready handshake and turns it into the chip-select, write-enable and output-enable waveforms the RAM needs. Each strobe window is measured in clock cycles. The counts are worked out at elaboration from nanosecond parameters and the clock period: each is rounded up and is never less than one cycle.

A request carries an address, a write flag and write data. The requester holds `req_valid` and the payload steady until a clock edge where `req_ready` is also high. Exactly one request is taken at that edge. `req_ready` is low while an access or a wake-up wait is in progress. Read results come back on `rsp_data` with a single-cycle `rsp_valid` pulse. There is no back-pressure on the response side, so the requester must take a response in the cycle it appears.

A plain `sleep_req` control deselects the RAM and disables its outputs for low-power retention. When it is released, the block waits one read-cycle time before the first access can start. Before driving write data, a write cycle always waits out the RAM's output float time after write enable falls.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset the RAM is selected (`ram_cs1_n`=0, `ram_cs2`=1) with `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A read holds the chip selected with `ram_we_n`=1 and `ram_oe_n`=0 for `RD_CYC` cycles (10 at defaults, at least 40 ns). The address stays stable through the whole window, and write enable and output enable are never low together.
- R3: Read data is sampled on the last cycle of the read window. It is returned with a one-cycle `rsp_valid` pulse and equals the byte last written to that address.
- R4: A write holds `ram_we_n` low for at least 28 ns. `ram_dq_oe` is high, with stable data, for at least 18 ns before `ram_we_n` rises. `ram_dq_oe` stays high through that rising edge. The data bus is only driven while `ram_oe_n`=1 and the chip is selected.
- R5: `ram_dq_oe` rises no sooner than 15 ns after `ram_we_n` falls and no sooner than 10 ns after `ram_oe_n` rises, so the controller never drives the bus while the RAM's outputs may still be on.
- R6: The address is valid at least 28 ns before a write ends and does not change for at least 3 ns after it. A write occupies at least 35 ns.
- R7: `req_ready` is low in every cycle of an access or recovery wait. It is high only while no strobe is active (`ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0).
- R8: While `sleep_req` is held in idle, the outputs go to `ram_cs1_n`=1, `ram_cs2`=0, `ram_oe_n`=1 and `ram_we_n`=1, and `req_ready`=0. A request presented then is not accepted.
- R9: After `sleep_req` falls, no strobe starts for at least 40 ns. `req_ready` returns exactly 11 cycles later at defaults (1 edge to leave standby plus `REC_CYC`=10). Data written before standby reads back unchanged.
- R10: The sequencer state is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-result pulse |
| rsp_data | output | 8 | Read result |
| sleep_req | input | 1 | Hold high for retention standby |
| ram_cs1_n | output | 1 | Active-low chip select |
| ram_cs2 | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_addr | output | 17 | RAM address |
| ram_dq_o | output | 8 | Data toward RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | 8 | Data from RAM |

## Verification
The bench uses a timing-aware RAM model. The model puts out a garbage byte until its access times have passed, so a read window that is one cycle short returns the wrong value rather than a lucky match. Writes to the lowest and highest addresses and to alternating-bit addresses, with data 00, FF, A5 and 5A, tell apart stuck or swapped address and data lines. Back-to-back reads of all-zero and all-one addresses check that the address stays stable within a window. A read followed by a write to the same location exercises the bus turnaround. The model timestamps every strobe edge, so a shortened turnaround, pulse or recovery count shows up as a timing failure. A standby round trip checks the deselected pins, the wake-up delay and that the data survives.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [6:0] {
    ST_IDLE      = 7'b0000001,
    ST_RD_ACCESS = 7'b0000010,
    ST_WR_TURN   = 7'b0000100,
    ST_WR_PULSE  = 7'b0001000,
    ST_WR_HOLD   = 7'b0010000,
    ST_STANDBY   = 7'b0100000,
    ST_RECOVER   = 7'b1000000
  } ctrl_state_e;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned q;
    q = (ns + clk_ns - 1) / clk_ns;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a minus b, but at least one
  function automatic int unsigned rem_min1(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

  // pin levels belonging to each state
  function automatic pin_ctl_t pins_for(ctrl_state_e s);
    pin_ctl_t p;
    p.cs1_n = 1'b0;
    p.cs2   = 1'b1;
    p.we_n  = 1'b1;
    p.oe_n  = 1'b1;
    p.dq_oe = 1'b0;
    case (s)
      ST_RD_ACCESS: p.oe_n = 1'b0;
      ST_WR_TURN:   p.we_n = 1'b0;
      ST_WR_PULSE: begin
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WR_HOLD:   p.dq_oe = 1'b1;
      ST_STANDBY, ST_RECOVER: begin
        p.cs1_n = 1'b1;
        p.cs2   = 1'b0;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC    = 10,
  parameter int unsigned TURN_CYC  = 4,
  parameter int unsigned PULSE_CYC = 5,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned REC_CYC   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        req_write,
  input  logic        sleep_req,
  output ctrl_state_e state_q,
  output ctrl_state_e state_d,
  output logic        step_last
);

  localparam int unsigned MAXC = max2(max2(RD_CYC, REC_CYC),
                                      max2(max2(TURN_CYC, PULSE_CYC), HOLD_CYC));
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_load;

  assign step_last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (sleep_req)     state_d = ST_STANDBY;
        else if (req_fire) state_d = req_write ? ST_WR_TURN : ST_RD_ACCESS;
      end
      ST_RD_ACCESS: if (step_last) state_d = ST_IDLE;
      ST_WR_TURN:   if (step_last) state_d = ST_WR_PULSE;
      ST_WR_PULSE:  if (step_last) state_d = ST_WR_HOLD;
      ST_WR_HOLD:   if (step_last) state_d = ST_IDLE;
      ST_STANDBY:   if (!sleep_req) state_d = ST_RECOVER;
      ST_RECOVER:   if (step_last) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // cycles still to spend in the state about to be entered, minus one
  always_comb begin
    case (state_d)
      ST_RD_ACCESS: cnt_load = CW'(RD_CYC - 1);
      ST_WR_TURN:   cnt_load = CW'(TURN_CYC - 1);
      ST_WR_PULSE:  cnt_load = CW'(PULSE_CYC - 1);
      ST_WR_HOLD:   cnt_load = CW'(HOLD_CYC - 1);
      ST_RECOVER:   cnt_load = CW'(REC_CYC - 1);
      default:      cnt_load = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)  cnt_q <= cnt_load;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sram_pin_driver.sv
`timescale 1ns/1ps
module sram_pin_driver
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_e       state_d,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ram_cs1_n,
  output logic              ram_cs2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_dq_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o
);

  pin_ctl_t pin_d;
  pin_ctl_t pin_q;

  // registered from the next state so every strobe lines up with its state and cannot glitch
  assign pin_d = pins_for(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= pins_for(ST_IDLE);
    end else begin
      pin_q <= pin_d;
    end
  end

  // address and data change only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr <= '0;
      ram_dq_o <= '0;
    end else if (req_fire) begin
      ram_addr <= req_addr;
      ram_dq_o <= req_wdata;
    end
  end

  assign ram_cs1_n = pin_q.cs1_n;
  assign ram_cs2   = pin_q.cs2;
  assign ram_we_n  = pin_q.we_n;
  assign ram_oe_n  = pin_q.oe_n;
  assign ram_dq_oe = pin_q.dq_oe;

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture_en;
      if (capture_en) rsp_data <= ram_dq_i;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_RC_NS   = 40,
  parameter int unsigned T_AA_NS   = 40,
  parameter int unsigned T_OE_NS   = 12,
  parameter int unsigned T_WC_NS   = 35,
  parameter int unsigned T_WP_NS   = 28,
  parameter int unsigned T_AW_NS   = 28,
  parameter int unsigned T_DS_NS   = 18,
  parameter int unsigned T_AH_NS   = 3,
  parameter int unsigned T_OEZ_NS  = 10,
  parameter int unsigned T_WEZ_NS  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              sleep_req,
  output logic              ram_cs1_n,
  output logic              ram_cs2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i
);

  // cycle counts derived from the nanosecond limits
  localparam int unsigned RD_CYC    = max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                           max2(ns_to_cyc(T_AA_NS, CLK_NS),
                                                ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int unsigned TURN_CYC  = max2(ns_to_cyc(T_WEZ_NS, CLK_NS),
                                           ns_to_cyc(T_OEZ_NS, CLK_NS));
  localparam int unsigned PULSE_CYC = max2(ns_to_cyc(T_DS_NS, CLK_NS),
                                           max2(rem_min1(ns_to_cyc(T_WP_NS, CLK_NS), TURN_CYC),
                                                rem_min1(ns_to_cyc(T_AW_NS, CLK_NS), TURN_CYC)));
  localparam int unsigned HOLD_CYC  = max2(ns_to_cyc(T_AH_NS, CLK_NS),
                                           rem_min1(ns_to_cyc(T_WC_NS, CLK_NS),
                                                    TURN_CYC + PULSE_CYC));
  localparam int unsigned REC_CYC   = ns_to_cyc(T_RC_NS, CLK_NS);

  ctrl_state_e state_q;
  ctrl_state_e state_d;
  logic        step_last;
  logic        req_fire;
  logic        capture_en;

  assign req_ready  = (state_q == ST_IDLE) && !sleep_req;
  assign req_fire   = req_valid && req_ready;
  assign capture_en = (state_q == ST_RD_ACCESS) && step_last;

  sram_seq_fsm #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .REC_CYC  (REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_write(req_write),
    .sleep_req(sleep_req),
    .state_q  (state_q),
    .state_d  (state_d),
    .step_last(step_last)
  );

  sram_pin_driver #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_d  (state_d),
    .req_fire (req_fire),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ram_cs1_n(ram_cs1_n),
    .ram_cs2  (ram_cs2),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .ram_dq_oe(ram_dq_oe),
    .ram_addr (ram_addr),
    .ram_dq_o (ram_dq_o)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_en(capture_en),
    .ram_dq_i  (ram_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sleep_req,
  input logic              ram_cs1_n,
  input logic              ram_cs2,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [6:0]        state_q
);

  assert_onehot_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);

  assert_we_oe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  assert_addr_stable_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_oe_n && $past(!ram_oe_n)) |-> $stable(ram_addr));

  assert_rsp_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_drive_only_writing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_cs1_n && ram_cs2 && ram_oe_n));

  assert_drive_after_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> ($past(!ram_we_n) && !ram_we_n));

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_we_n && ram_oe_n && !ram_dq_oe));

  assert_standby_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && $past(sleep_req) && ram_cs1_n) |-> (!ram_cs2 && ram_we_n && ram_oe_n && !req_ready));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .sleep_req(sleep_req),
  .ram_cs1_n(ram_cs1_n),
  .ram_cs2  (ram_cs2),
  .ram_we_n (ram_we_n),
  .ram_oe_n (ram_oe_n),
  .ram_dq_oe(ram_dq_oe),
  .ram_addr (ram_addr),
  .state_q  (state_q)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          sleep_req = 1'b0;
  logic          ram_cs1_n, ram_cs2, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_dq_o;
  logic [DW-1:0] ram_dq_i = 8'hEE;

  always #2 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sleep_req(sleep_req),
    .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- timing-aware RAM model ----------------
  logic [DW-1:0] mem    [int];
  logic [DW-1:0] shadow [int];
  realtime addr_t = 0, oe_fall_t = -1000, oe_rise_t = -1000;
  realtime we_fall_t = -1000, we_rise_t = -1000, dq_t = 0, wake_t = -1000;
  wire sel = !ram_cs1_n && ram_cs2;

  function automatic int ns_since(realtime t);
    return int'($realtime - t);
  endfunction

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(ram_addr) begin
    if (rst_n) chk(($realtime - we_rise_t) >= 3.0, "R6", "addr hold after write ns", ns_since(we_rise_t), 3);
    addr_t = $realtime;
  end

  always @(ram_dq_o or ram_dq_oe) dq_t = $realtime;
  always @(negedge ram_oe_n) oe_fall_t = $realtime;
  always @(negedge ram_we_n) we_fall_t = $realtime;

  always @(posedge ram_oe_n) begin
    oe_rise_t = $realtime;
    if (rst_n && sel && ram_we_n) begin
      chk(($realtime - oe_fall_t) >= 40.0, "R2", "read strobe ns", ns_since(oe_fall_t), 40);
      chk(($realtime - addr_t) >= 40.0, "R2", "read addr stable ns", ns_since(addr_t), 40);
    end
  end

  always @(posedge ram_we_n) begin
    if (rst_n && sel) begin
      chk(($realtime - we_fall_t) >= 28.0, "R4", "we low ns", ns_since(we_fall_t), 28);
      chk(ram_dq_oe && (($realtime - dq_t) >= 18.0), "R4", "data setup ns", ns_since(dq_t), 18);
      chk(($realtime - addr_t) >= 28.0, "R6", "addr valid to write end ns", ns_since(addr_t), 28);
      mem[int'(ram_addr)] = ram_dq_o;
      we_rise_t = $realtime;
    end
  end

  always @(posedge ram_dq_oe) begin
    if (rst_n)
      chk(ram_oe_n && (($realtime - we_fall_t) >= 15.0) && (($realtime - oe_rise_t) >= 10.0),
          "R5", "drive after float ns", ns_since(we_fall_t), 15);
  end

  always @(negedge ram_oe_n or negedge ram_we_n) begin
    if (rst_n && wake_t >= 0.0) begin
      chk(($realtime - wake_t) >= 40.0, "R9", "first strobe after wake ns", ns_since(wake_t), 40);
      wake_t = -1000;
    end
  end

  // output is garbage until address and output-enable access times are met
  initial begin
    #0.5;
    forever begin
      if (sel && ram_we_n && !ram_oe_n &&
          ($realtime + 0.5 - addr_t >= 40.0) && ($realtime + 0.5 - oe_fall_t >= 12.0))
        ram_dq_i = mem_rd(ram_addr);
      else
        ram_dq_i = 8'hEE;
      #1;
    end
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] expq[$];
  int issued = 0;
  int returned = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      returned++;
      if (expq.size() == 0) chk(1'b0, "R3", "unexpected response", rsp_data, 0);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R3", "read data", rsp_data, e);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[int'(a)] = d;
    else begin
      expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      issued++;
    end
    @(negedge clk);
    chk(!req_ready, "R7", "ready low during access", req_ready, 0);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    chk(!ram_cs1_n && ram_cs2, "R1", "selects", {ram_cs1_n, ram_cs2}, 1);
    chk(ram_we_n && ram_oe_n, "R1", "we/oe", {ram_we_n, ram_oe_n}, 3);
    chk(!ram_dq_oe, "R1", "dq_oe", ram_dq_oe, 0);
    chk(!rsp_valid, "R1", "rsp_valid", rsp_valid, 0);

    // writes over edge addresses and data patterns
    do_req(1'b1, 17'h00000, 8'h00);
    do_req(1'b1, 17'h1FFFF, 8'hFF);
    do_req(1'b1, 17'h0AAAA, 8'hA5);
    do_req(1'b1, 17'h15555, 8'h5A);
    do_req(1'b1, 17'h12345, 8'h81);
    // reads back in another order (R3)
    do_req(1'b0, 17'h15555, 8'h00);
    do_req(1'b0, 17'h00000, 8'h00);
    do_req(1'b0, 17'h1FFFF, 8'h00);
    do_req(1'b0, 17'h0AAAA, 8'h00);
    do_req(1'b0, 17'h00000, 8'h00);
    do_req(1'b0, 17'h1FFFF, 8'h00);
    // read then write same address: turnaround (R5)
    do_req(1'b0, 17'h12345, 8'h00);
    do_req(1'b1, 17'h12345, 8'h3C);
    do_req(1'b0, 17'h12345, 8'h00);
    drain();

    // standby (R8) with a request pending that must not be taken
    @(negedge clk);
    sleep_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0AAAA; req_wdata = 8'h11;
    repeat (6) @(negedge clk);
    chk(ram_cs1_n && !ram_cs2, "R8", "standby selects", {ram_cs1_n, ram_cs2}, 2);
    chk(ram_oe_n && ram_we_n, "R8", "standby we/oe", {ram_we_n, ram_oe_n}, 3);
    chk(!req_ready, "R8", "ready in standby", req_ready, 0);
    chk(!ram_dq_oe, "R8", "no drive in standby", ram_dq_oe, 0);
    req_valid = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    wake_t = $realtime;
    begin
      int n;
      n = 0;
      while (!req_ready && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(n == 11, "R9", "cycles until ready after wake", n, 11);
    end
    // retention: pending write was not taken, data unchanged (R8, R9)
    do_req(1'b0, 17'h0AAAA, 8'h00);
    do_req(1'b0, 17'h12345, 8'h00);
    drain();
    chk(returned == issued, "R3", "response count", returned, issued);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule